// File: doc/BRIEF.md
# Downconverter Output Test Pattern Generator

This block sits at the end of one downconverter channel, where the in-phase (I) and quadrature (Q) streams leave the datapath as 16-bit words. Each stream has its own 4-bit pattern select. A select either lets the live converter samples through or puts a synthetic word in their place. The synthetic words are fixed constants, an alternating-bit toggle, a rising ramp, a single user word, or two user words in turn. The two user words come from a configuration register file as plain 16-bit inputs, and both streams share them.

A sample moves forward on each clock where the input valid is high. The word for that sample comes out one clock later, taken from a register, together with a delayed copy of the valid. Pattern state changes only on valid cycles. This covers the ramp count and the phase of the two alternating modes. When a stream enters a different pattern, that state starts over on the first valid sample taken under the new select. Link bring-up and bench testing use the block to place known data on the output lanes without changing the datapath above it.

Top module: `ddc_test_pattern_gen`

## Requirements
- R1: While reset is high, and on the first clock after it, out_valid is 0 and out_i and out_q are 0. Both streams start as if the previous select was pass-through.
- R2: Select 4'h0 passes the stream's input sample through unchanged. The unused codes 4'h5 and 4'hA to 4'hF behave exactly like 4'h0.
- R3: Select 4'h1 outputs 16'h0000 and select 4'h2 outputs 16'hFFFF.
- R4: Select 4'h3 outputs 16'hAAAA on the first valid sample under that select, then 16'h5555, and keeps alternating between the two on each valid sample.
- R5: Select 4'h4 outputs a ramp. It is 0 on the first valid sample under that select and rises by 1 on each valid sample after that. After 16'hFFFF it wraps to 16'h0000.
- R6: Select 4'h6 outputs the cust1 input on every valid sample.
- R7: Select 4'h7 outputs cust1 on the first valid sample under that select, then cust2, and keeps alternating between the two on each valid sample.
- R8: Select 4'h8 outputs the deskew word 16'hAAAA and select 4'h9 outputs the sync word 16'hFFFF.
- R9: mode_i controls only out_i and mode_q controls only out_q, so the two streams can run different patterns at the same time.
- R10: out_valid equals in_valid one clock later, and each output word belongs to the sample taken one clock before. On cycles where in_valid is 0, the output words hold their values and no pattern state changes.
- R11: A select change applies from the next valid sample. When a stream moves to a different pattern, its ramp restarts at 0 and its alternation restarts at the first word.
- R12: The pass-through samples and the custom words are taken in the same clock as the valid sample they belong to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A sample is present this cycle |
| in_i | input | 16 | Converter I sample |
| in_q | input | 16 | Converter Q sample |
| mode_i | input | 4 | Pattern select for the I stream |
| mode_q | input | 4 | Pattern select for the Q stream |
| cust1 | input | 16 | First user pattern word |
| cust2 | input | 16 | Second user pattern word |
| out_valid | output | 1 | Output word is valid |
| out_i | output | 16 | I output word |
| out_q | output | 16 | Q output word |

## Verification
The assertions check the stateless parts of the block on every cycle: the valid delay, the hold on idle cycles, pass-through, the constant words, and the single custom word. They also check that the toggle and double modes only ever produce one of their two words, and that each ramp step is exactly one above the previous output. Only the bench scenarios can show behaviour that depends on history. This includes which word an alternating mode starts with, the ramp restarting after a select change, the wrap after 65535 steps, and two streams running different patterns without affecting each other.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

    localparam int TPG_DATA_W = 16;
    localparam int TPG_MODE_W = 4;
    localparam int TPG_LANES  = 2;

    localparam logic [TPG_MODE_W-1:0] MODE_PASS   = 4'h0;
    localparam logic [TPG_MODE_W-1:0] MODE_ZERO   = 4'h1;
    localparam logic [TPG_MODE_W-1:0] MODE_ONES   = 4'h2;
    localparam logic [TPG_MODE_W-1:0] MODE_TOGGLE = 4'h3;
    localparam logic [TPG_MODE_W-1:0] MODE_RAMP   = 4'h4;
    localparam logic [TPG_MODE_W-1:0] MODE_CUST1  = 4'h6;
    localparam logic [TPG_MODE_W-1:0] MODE_DOUBLE = 4'h7;
    localparam logic [TPG_MODE_W-1:0] MODE_DESKEW = 4'h8;
    localparam logic [TPG_MODE_W-1:0] MODE_SYNC   = 4'h9;

    typedef enum logic [3:0] {
        KIND_PASS,
        KIND_ZERO,
        KIND_ONES,
        KIND_TOGGLE,
        KIND_RAMP,
        KIND_CUST1,
        KIND_DOUBLE,
        KIND_DESKEW,
        KIND_SYNC
    } pat_kind_e;

    typedef struct packed {
        pat_kind_e kind;
        logic      fresh;
    } pat_ctl_t;

    // Unused codes fall back to pass-through.
    function automatic pat_kind_e decode_mode(input logic [TPG_MODE_W-1:0] code);
        pat_kind_e k;
        case (code)
            MODE_ZERO:   k = KIND_ZERO;
            MODE_ONES:   k = KIND_ONES;
            MODE_TOGGLE: k = KIND_TOGGLE;
            MODE_RAMP:   k = KIND_RAMP;
            MODE_CUST1:  k = KIND_CUST1;
            MODE_DOUBLE: k = KIND_DOUBLE;
            MODE_DESKEW: k = KIND_DESKEW;
            MODE_SYNC:   k = KIND_SYNC;
            default:     k = KIND_PASS;
        endcase
        return k;
    endfunction

    function automatic logic uses_phase(input pat_kind_e k);
        return (k == KIND_TOGGLE) || (k == KIND_DOUBLE);
    endfunction

endpackage

// File: rtl/tpg_mode_track.sv
module tpg_mode_track
    import tpg_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  adv,
    input  logic [TPG_MODE_W-1:0] mode,
    output pat_ctl_t              ctl
);

    pat_kind_e kind_now;
    pat_kind_e kind_last;

    always_comb begin
        kind_now  = decode_mode(mode);
        ctl.kind  = kind_now;
        ctl.fresh = (kind_now != kind_last);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            kind_last <= KIND_PASS;
        end else if (adv) begin
            kind_last <= kind_now;
        end
    end

endmodule

// File: rtl/tpg_seq_state.sv
module tpg_seq_state
    import tpg_pkg::*;
#(
    parameter int DATA_W = TPG_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv,
    input  pat_ctl_t          ctl,
    output logic [DATA_W-1:0] ramp_cur,
    output logic              phase_cur
);

    logic [DATA_W-1:0] ramp_q;
    logic              phase_q;

    always_comb begin
        ramp_cur  = ctl.fresh ? '0   : ramp_q;
        phase_cur = ctl.fresh ? 1'b0 : phase_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ramp_q  <= '0;
            phase_q <= 1'b0;
        end else if (adv) begin
            if (ctl.kind == KIND_RAMP) begin
                ramp_q <= ramp_cur + 1'b1;
            end
            if (uses_phase(ctl.kind)) begin
                phase_q <= ~phase_cur;
            end
        end
    end

endmodule

// File: rtl/tpg_word_mux.sv
module tpg_word_mux
    import tpg_pkg::*;
#(
    parameter int DATA_W = TPG_DATA_W
) (
    input  pat_kind_e         kind,
    input  logic [DATA_W-1:0] sample,
    input  logic [DATA_W-1:0] cust1,
    input  logic [DATA_W-1:0] cust2,
    input  logic [DATA_W-1:0] ramp_cur,
    input  logic              phase_cur,
    output logic [DATA_W-1:0] word
);

    // Alternating-bit word with the MSB set when DATA_W is even.
    logic [DATA_W-1:0] alt_hi;

    genvar b;
    generate
        for (b = 0; b < DATA_W; b++) begin : g_alt
            assign alt_hi[b] = (b % 2) == 1;
        end
    endgenerate

    always_comb begin
        case (kind)
            KIND_ZERO:   word = '0;
            KIND_ONES:   word = '1;
            KIND_TOGGLE: word = phase_cur ? ~alt_hi : alt_hi;
            KIND_RAMP:   word = ramp_cur;
            KIND_CUST1:  word = cust1;
            KIND_DOUBLE: word = phase_cur ? cust2 : cust1;
            KIND_DESKEW: word = alt_hi;
            KIND_SYNC:   word = '1;
            default:     word = sample;
        endcase
    end

endmodule

// File: rtl/tpg_lane.sv
module tpg_lane
    import tpg_pkg::*;
#(
    parameter int DATA_W = TPG_DATA_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic [DATA_W-1:0]     sample,
    input  logic [TPG_MODE_W-1:0] mode,
    input  logic [DATA_W-1:0]     cust1,
    input  logic [DATA_W-1:0]     cust2,
    output logic [DATA_W-1:0]     word_q
);

    pat_ctl_t          ctl;
    logic [DATA_W-1:0] ramp_cur;
    logic              phase_cur;
    logic [DATA_W-1:0] word_d;

    tpg_mode_track u_track (
        .clk  (clk),
        .rst  (rst),
        .adv  (in_valid),
        .mode (mode),
        .ctl  (ctl)
    );

    tpg_seq_state #(.DATA_W(DATA_W)) u_state (
        .clk       (clk),
        .rst       (rst),
        .adv       (in_valid),
        .ctl       (ctl),
        .ramp_cur  (ramp_cur),
        .phase_cur (phase_cur)
    );

    tpg_word_mux #(.DATA_W(DATA_W)) u_mux (
        .kind      (ctl.kind),
        .sample    (sample),
        .cust1     (cust1),
        .cust2     (cust2),
        .ramp_cur  (ramp_cur),
        .phase_cur (phase_cur),
        .word      (word_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
        end else if (in_valid) begin
            word_q <= word_d;
        end
    end

endmodule

// File: rtl/ddc_test_pattern_gen.sv
module ddc_test_pattern_gen
    import tpg_pkg::*;
#(
    parameter int DATA_W = TPG_DATA_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic [DATA_W-1:0]     in_i,
    input  logic [DATA_W-1:0]     in_q,
    input  logic [TPG_MODE_W-1:0] mode_i,
    input  logic [TPG_MODE_W-1:0] mode_q,
    input  logic [DATA_W-1:0]     cust1,
    input  logic [DATA_W-1:0]     cust2,
    output logic                  out_valid,
    output logic [DATA_W-1:0]     out_i,
    output logic [DATA_W-1:0]     out_q
);

    localparam int LANE_I = 0;
    localparam int LANE_Q = 1;

    logic [DATA_W-1:0]     lane_sample [TPG_LANES];
    logic [TPG_MODE_W-1:0] lane_mode   [TPG_LANES];
    logic [DATA_W-1:0]     lane_word   [TPG_LANES];

    assign lane_sample[LANE_I] = in_i;
    assign lane_sample[LANE_Q] = in_q;
    assign lane_mode[LANE_I]   = mode_i;
    assign lane_mode[LANE_Q]   = mode_q;

    genvar g;
    generate
        for (g = 0; g < TPG_LANES; g++) begin : g_lane
            tpg_lane #(.DATA_W(DATA_W)) u_lane (
                .clk      (clk),
                .rst      (rst),
                .in_valid (in_valid),
                .sample   (lane_sample[g]),
                .mode     (lane_mode[g]),
                .cust1    (cust1),
                .cust2    (cust2),
                .word_q   (lane_word[g])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
        end
    end

    assign out_i = lane_word[LANE_I];
    assign out_q = lane_word[LANE_Q];

endmodule

// File: rtl/ddc_test_pattern_gen_chk.sv
module ddc_test_pattern_gen_chk
    import tpg_pkg::*;
#(
    parameter int DATA_W = TPG_DATA_W
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  in_valid,
    input logic [DATA_W-1:0]     in_i,
    input logic [DATA_W-1:0]     in_q,
    input logic [TPG_MODE_W-1:0] mode_i,
    input logic [TPG_MODE_W-1:0] mode_q,
    input logic [DATA_W-1:0]     cust1,
    input logic [DATA_W-1:0]     cust2,
    input logic                  out_valid,
    input logic [DATA_W-1:0]     out_i,
    input logic [DATA_W-1:0]     out_q
);

    function automatic logic [DATA_W-1:0] alt_word();
        logic [DATA_W-1:0] w;
        for (int k = 0; k < DATA_W; k++) begin
            w[k] = (k % 2) == 1;
        end
        return w;
    endfunction

    localparam logic [DATA_W-1:0] ALT = alt_word();

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (!out_valid && out_i == '0 && out_q == '0));

    a_r10_valid_rise: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r10_valid_fall: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    a_r10_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_i) && $stable(out_q)));

    a_r2_pass_i: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode_i == MODE_PASS) |=> out_i == $past(in_i));

    a_r2_pass_q: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode_q == MODE_PASS) |=> out_q == $past(in_q));

    a_r3_zero_i: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode_i == MODE_ZERO) |=> out_i == '0);

    a_r3_ones_q: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode_q == MODE_ONES) |=> out_q == '1);

    a_r4_toggle_i: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode_i == MODE_TOGGLE) |=> (out_i == ALT || out_i == ~ALT));

    a_r5_ramp_step_i: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode_i == MODE_RAMP && $past(in_valid && mode_i == MODE_RAMP))
        |=> out_i == $past(out_i) + 1'b1);

    a_r6_cust1_q: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode_q == MODE_CUST1) |=> out_q == $past(cust1));

    a_r7_double_i: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode_i == MODE_DOUBLE) |=> (out_i == $past(cust1) || out_i == $past(cust2)));

    a_r8_deskew_i: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode_i == MODE_DESKEW) |=> out_i == ALT);

    a_r8_sync_q: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode_q == MODE_SYNC) |=> out_q == '1);

endmodule

bind ddc_test_pattern_gen ddc_test_pattern_gen_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/ddc_test_pattern_gen_test.sv
module ddc_test_pattern_gen_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 200000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] in_i = '0;
    logic [15:0] in_q = '0;
    logic [3:0]  mode_i = '0;
    logic [3:0]  mode_q = '0;
    logic [15:0] cust1 = '0;
    logic [15:0] cust2 = '0;
    logic        out_valid;
    logic [15:0] out_i;
    logic [15:0] out_q;

    always #(CLK_PERIOD/2) clk = ~clk;

    ddc_test_pattern_gen uut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .in_i(in_i), .in_q(in_q), .mode_i(mode_i), .mode_q(mode_q),
        .cust1(cust1), .cust2(cust2),
        .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
    );

    typedef struct {
        logic [15:0] ei;
        logic [15:0] eq;
        string       ti;
        string       tq;
    } exp_t;

    exp_t sb[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 0;

    // Reference state per stream: last code class, ramp count, phase.
    int          m_last [2] = '{0, 0};
    logic [15:0] m_cnt  [2] = '{16'h0, 16'h0};
    bit          m_ph   [2] = '{1'b0, 1'b0};

    function automatic logic [15:0] model(input int lane, input logic [3:0] m,
                                          input logic [15:0] s, c1, c2,
                                          output string tag);
        int          k;
        bit          fresh;
        bit          ph;
        logic [15:0] c;
        logic [15:0] r;
        k = (m inside {4'h1, 4'h2, 4'h3, 4'h4, 4'h6, 4'h7, 4'h8, 4'h9}) ? int'(m) : 0;
        fresh = (k != m_last[lane]);
        m_last[lane] = k;
        case (k)
            1: begin r = 16'h0000; tag = "R3"; end
            2: begin r = 16'hFFFF; tag = "R3"; end
            3: begin
                ph = fresh ? 1'b0 : m_ph[lane];
                r = ph ? 16'h5555 : 16'hAAAA;
                m_ph[lane] = ~ph;
                tag = "R4";
            end
            4: begin
                c = fresh ? 16'h0 : m_cnt[lane];
                r = c;
                m_cnt[lane] = c + 16'h1;
                tag = "R5";
            end
            6: begin r = c1; tag = "R6"; end
            7: begin
                ph = fresh ? 1'b0 : m_ph[lane];
                r = ph ? c2 : c1;
                m_ph[lane] = ~ph;
                tag = "R7";
            end
            8: begin r = 16'hAAAA; tag = "R8"; end
            9: begin r = 16'hFFFF; tag = "R8"; end
            default: begin r = s; tag = "R2"; end
        endcase
        return r;
    endfunction

    task automatic send(input bit v, input logic [15:0] si, sq,
                        input logic [3:0] mi, mq,
                        input logic [15:0] c1, c2, input string note);
        exp_t e;
        string a, b;
        @(negedge clk);
        in_valid = v; in_i = si; in_q = sq; mode_i = mi; mode_q = mq;
        cust1 = c1; cust2 = c2;
        if (v) begin
            e.ei = model(0, mi, si, c1, c2, a);
            e.eq = model(1, mq, sq, c1, c2, b);
            e.ti = {a, "/", note};
            e.tq = {b, "/", note};
            sb.push_back(e);
        end
    endtask

    task automatic check(input bit ok, input string req, input logic [15:0] act, exp_v);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp_v, $time);
        end
    endtask

    // Monitor: compare each produced word against the scoreboard.
    logic [15:0] held_i = '0;
    logic [15:0] held_q = '0;
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (out_valid) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R10 unexpected out_valid", {15'h0, out_valid}, 16'h0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(out_i === e.ei, {e.ti, " lane I"}, out_i, e.ei);
                    check(out_q === e.eq, {e.tq, " lane Q"}, out_q, e.eq);
                end
                held_i = out_i;
                held_q = out_q;
            end else begin
                check(out_i === held_i, "R10 hold lane I", out_i, held_i);
                check(out_q === held_q, "R10 hold lane Q", out_q, held_q);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * WATCHDOG_CYCLES);
        if (!done) begin
            done = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    localparam logic [15:0] C1 = 16'h7531;
    localparam logic [15:0] C2 = 16'h0F0E;

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state observed while reset is still high
        check(out_valid === 1'b0, "R1 out_valid", {15'h0, out_valid}, 16'h0);
        check(out_i === 16'h0, "R1 out_i", out_i, 16'h0);
        check(out_q === 16'h0, "R1 out_q", out_q, 16'h0);
        rst = 1'b0;

        // R2: pass-through
        for (int n = 0; n < 8; n++)
            send(1, 16'h1000 + 16'(n * 37), 16'hC000 - 16'(n * 91), 4'h0, 4'h0, C1, C2, "pass");
        // R2: unused codes act as pass-through
        for (int n = 0; n < 6; n++)
            send(1, 16'h2200 + 16'(n), 16'h3300 + 16'(n), 4'h5, 4'(10 + n), C1, C2, "reserved");

        // R3 and R9: constants, lanes independent
        for (int n = 0; n < 3; n++) send(1, 16'h1234, 16'h4321, 4'h1, 4'h2, C1, C2, "R9 const");
        for (int n = 0; n < 3; n++) send(1, 16'h1234, 16'h4321, 4'h2, 4'h1, C1, C2, "R9 swap");

        // R4 toggle with idle gaps (R10: phase frozen while idle)
        for (int n = 0; n < 8; n++)
            send((n % 2) == 0, 16'h0BAD, 16'h5A5A + 16'(n), 4'h3, 4'h0, C1, C2, "R10 gaps");

        // R5 ramp with gaps on I, toggle on Q
        for (int n = 0; n < 20; n++)
            send((n % 3) != 2, 16'h0, 16'h0, 4'h4, 4'h3, C1, C2, "R10 ramp gaps");
        // R11: leave ramp and come back -> restart at 0
        send(1, 16'hBEEF, 16'h0, 4'h0, 4'h3, C1, C2, "R11 leave");
        send(1, 16'hCAFE, 16'h0, 4'h0, 4'h3, C1, C2, "R11 leave");
        for (int n = 0; n < 4; n++) send(1, 16'h0, 16'h0, 4'h4, 4'h3, C1, C2, "R11 reenter");

        // R6 and R12: custom word sampled with each sample
        for (int n = 0; n < 5; n++)
            send(1, 16'h0, 16'h0, 4'h6, 4'h6, 16'h0100 + 16'(n * 5), C2, "R12 cust1");

        // R7 double, then R11 restart through toggle
        for (int n = 0; n < 5; n++) send(1, 16'h0, 16'h0, 4'h7, 4'h7, C1, C2, "double");
        send(0, 16'h0, 16'h0, 4'h7, 4'h7, C1, C2, "R10 idle");
        send(1, 16'h0, 16'h0, 4'h7, 4'h7, C1, C2, "double after idle");
        send(1, 16'h0, 16'h0, 4'h3, 4'h7, C1, C2, "R11 to toggle");
        for (int n = 0; n < 3; n++)
            send(1, 16'h0, 16'h0, 4'h7, 4'h3, 16'h1111 + 16'(n), 16'h2222 + 16'(n), "R11 R12 back");

        // R8 deskew and sync
        for (int n = 0; n < 3; n++) send(1, 16'h0F0F, 16'hF0F0, 4'h8, 4'h9, C1, C2, "deskew sync");
        for (int n = 0; n < 2; n++) send(1, 16'h0F0F, 16'hF0F0, 4'h9, 4'h8, C1, C2, "sync deskew");

        // R5 wrap past 16'hFFFF on I while Q shows pass-through
        for (int n = 0; n < 65540; n++)
            send(1, 16'h0, 16'(n), 4'h4, 4'h0, C1, C2, "wrap");

        for (int n = 0; n < 4; n++) send(0, 16'h0, 16'h0, 4'h0, 4'h0, C1, C2, "drain");
        @(negedge clk);
        check(sb.size() == 0, "R10 all samples produced", 16'(sb.size()), 16'h0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule